// File: doc/BRIEF.md
# Flagged Arithmetic/Logic Unit

This block is the execute stage arithmetic unit of a small load/store processor. It combines a 32-bit arithmetic and logic datapath with a 5-bit status register. The datapath takes a 4-bit operation code, a destination operand and a source operand, and it computes the result combinationally within one cycle. The source operand is either a register value or a zero-extended 12-bit immediate. That choice is made upstream, so the block treats both the same way.

Five operations are supported: add, multiply (low word kept), bitwise invert of the source, logical right shift and right rotate. For shift and rotate, the destination value is moved by a count taken from the low bits of the source operand. Every result produces a set of flags. These are negative, zero, odd parity, even and carry. The flags are captured into the status register on a rising clock edge when the flag write enable is high and the operation code is one of the five valid codes.

There is no state machine. The only sequential element is the status register. It has two conditions: it is cleared by reset, and it is loaded when the flag write enable is high and the code is valid. Otherwise it holds its value.

Top module: `flagged_alu`

## Requirements
- R1: With `op` = 4'h4, `result` is (`dst_val` + `src_val`) mod 2^32. The carry flag that is captured is the carry out of bit 31. For every other valid code the captured carry is 0.
- R2: With `op` = 4'h5, `result` is the low 32 bits of `dst_val` * `src_val`.
- R3: With `op` = 4'h6, `result` is the bitwise inverse of `src_val`. `dst_val` has no effect on the result.
- R4: With `op` = 4'h7, `result` is `dst_val` shifted right logically by `src_val[4:0]` places, with zeros entering at bit 31.
- R5: With `op` = 4'h8, `result` is `dst_val` rotated right by `src_val[4:0]` places. Each bit that leaves bit 0 re-enters at bit 31.
- R6: For shift and rotate, only `src_val[4:0]` sets the count. A count of 0, including a source of 32, returns `dst_val` unchanged.
- R7: The flags have these positions in `status`:
  - bit 4 is negative, a copy of result bit 31;
  - bit 3 is zero, set when the result is all zeros;
  - bit 2 is parity, set when the result has an odd number of ones;
  - bit 1 is even, set when result bit 0 is 0;
  - bit 0 is carry.
- R8: On a rising edge, `status` loads the flags of the current result only when `flag_we` is 1 and `op` is in 4..8. Otherwise it holds its value.
- R9: An `op` outside 4..8 gives `result` = 0 and leaves `status` unchanged, even when `flag_we` is 1.
- R10: A synchronous `rst` high at a rising edge clears `status` to 0. Reset takes priority over `flag_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 4 | Operation code |
| dst_val | input | 32 | Destination operand |
| src_val | input | 32 | Source operand (register value or zero-extended immediate) |
| flag_we | input | 1 | Status register write enable |
| result | output | 32 | Combinational result |
| status | output | 5 | Status register {neg, zero, par, even, carry} |

## Verification
The bench targets several corner cases, each paired with the failure it exposes:
- An all-ones plus one addition. It must wrap to zero with carry and zero both set. A design that drops the 33rd bit, or reads zero before the wrap, reports the wrong flags.
- A source of 32 for shift and rotate. This has a zero count in its low bits. A design that uses the full source shifts everything out instead of returning the value unchanged.
- Rotations by 1 and by 31. These catch a rotate that fills with zeros or turns the wrong way.
- Invalid codes issued with the write enable high, and valid codes issued with the write enable low. A design that loads the status register regardless of either condition changes flags that must hold.
- A reset issued together with a valid write. This shows whether the reset priority is wrong.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned OPC_W   = 4;
    localparam int unsigned FLAG_W  = 5;

    localparam logic [OPC_W-1:0] OPC_ADD = 4'h4;
    localparam logic [OPC_W-1:0] OPC_MUL = 4'h5;
    localparam logic [OPC_W-1:0] OPC_INV = 4'h6;
    localparam logic [OPC_W-1:0] OPC_SHR = 4'h7;
    localparam logic [OPC_W-1:0] OPC_ROR = 4'h8;

    // Field order fixes the bit positions seen at the status port.
    typedef struct packed {
        logic neg;
        logic zero;
        logic par;
        logic even;
        logic carry;
    } flags_t;

endpackage

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int unsigned W  = 32,
    parameter int unsigned CW = $clog2(W)
) (
    input  logic [W-1:0]  val_in,
    input  logic [CW-1:0] amount,
    input  logic          rotate,
    output logic [W-1:0]  val_out
);

    logic [W-1:0] stage [0:CW];

    assign stage[0] = val_in;

    // One stage per count bit; stage k moves the word by 2**k places.
    for (genvar k = 0; k < CW; k++) begin : g_stage
        localparam int unsigned SH = 1 << k;
        logic [W-1:0] moved;
        always_comb begin
            if (rotate) begin
                moved = {stage[k][SH-1:0], stage[k][W-1:SH]};
            end else begin
                moved = {{SH{1'b0}}, stage[k][W-1:SH]};
            end
        end
        assign stage[k+1] = amount[k] ? moved : stage[k];
    end

    assign val_out = stage[CW];

endmodule

// File: rtl/alu_compute.sv
module alu_compute
    import alu_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned CW = $clog2(W)
) (
    input  logic [OPC_W-1:0] op,
    input  logic [W-1:0]     dst_val,
    input  logic [W-1:0]     src_val,
    output logic [W-1:0]     result,
    output logic             carry_out,
    output logic             op_valid
);

    logic [W:0]   sum_ext;
    logic [W-1:0] prod_lo;
    logic [W-1:0] shift_res;
    logic         is_rot;

    assign sum_ext = {1'b0, dst_val} + {1'b0, src_val};
    assign prod_lo = dst_val * src_val;
    assign is_rot  = (op == OPC_ROR);

    alu_shifter #(.W(W), .CW(CW)) u_shift (
        .val_in  (dst_val),
        .amount  (src_val[CW-1:0]),
        .rotate  (is_rot),
        .val_out (shift_res)
    );

    always_comb begin
        result    = '0;
        carry_out = 1'b0;
        op_valid  = 1'b1;
        unique case (op)
            OPC_ADD: begin
                result    = sum_ext[W-1:0];
                carry_out = sum_ext[W];
            end
            OPC_MUL: result = prod_lo;
            OPC_INV: result = ~src_val;
            OPC_SHR,
            OPC_ROR: result = shift_res;
            default: op_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] value,
    input  logic         carry_in,
    output flags_t       flags
);

    always_comb begin
        flags.neg   = value[W-1];
        flags.zero  = (value == '0);
        flags.par   = ^value;
        flags.even  = ~value[0];
        flags.carry = carry_in;
    end

endmodule

// File: rtl/flagged_alu.sv
module flagged_alu
    import alu_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned CW = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op,
    input  logic [W-1:0]      dst_val,
    input  logic [W-1:0]      src_val,
    input  logic              flag_we,
    output logic [W-1:0]      result,
    output logic [FLAG_W-1:0] status
);

    logic   carry_w;
    logic   valid_w;
    flags_t flags_w;
    flags_t status_q;

    alu_compute #(.W(W), .CW(CW)) u_compute (
        .op        (op),
        .dst_val   (dst_val),
        .src_val   (src_val),
        .result    (result),
        .carry_out (carry_w),
        .op_valid  (valid_w)
    );

    alu_flag_gen #(.W(W)) u_flags (
        .value    (result),
        .carry_in (carry_w),
        .flags    (flags_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else if (flag_we && valid_w) begin
            status_q <= flags_w;
        end
    end

    assign status = status_q;

endmodule

module flagged_alu_chk #(
    parameter int unsigned W  = 32,
    parameter int unsigned CW = $clog2(W)
) (
    input logic         clk,
    input logic         rst,
    input logic [3:0]   op,
    input logic [W-1:0] dst_val,
    input logic [W-1:0] src_val,
    input logic         flag_we,
    input logic [W-1:0] result,
    input logic [4:0]   status
);

    logic in_range;
    logic is_sh;
    assign in_range = (op >= 4'h4) && (op <= 4'h8);
    assign is_sh    = (op == 4'h7) || (op == 4'h8);

    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (status == 5'b0));

    a_r8_hold_without_we: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable(status));

    a_r9_hold_invalid: assert property (@(posedge clk) disable iff (rst)
        !in_range |=> $stable(status));

    a_r9_invalid_zero: assert property (@(posedge clk) disable iff (rst)
        !in_range |-> (result == '0));

    a_r7_zero_flag: assert property (@(posedge clk) disable iff (rst)
        (flag_we && in_range) |=> (status[3] == ($past(result) == '0)));

    a_r7_neg_flag: assert property (@(posedge clk) disable iff (rst)
        (flag_we && in_range) |=> (status[4] == $past(result[W-1])));

    a_r1_carry_cleared: assert property (@(posedge clk) disable iff (rst)
        (flag_we && in_range && op != 4'h4) |=> !status[0]);

    a_r3_invert: assert property (@(posedge clk) disable iff (rst)
        (op == 4'h6) |-> (result == ~src_val));

    a_r6_zero_count: assert property (@(posedge clk) disable iff (rst)
        (is_sh && src_val[CW-1:0] == '0) |-> (result == dst_val));

endmodule

bind flagged_alu flagged_alu_chk #(.W(W), .CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .dst_val (dst_val),
    .src_val (src_val),
    .flag_we (flag_we),
    .result  (result),
    .status  (status)
);

// File: tb/flagged_alu_test.sv
module flagged_alu_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op = 4'h0;
    logic [31:0] dst_val = '0;
    logic [31:0] src_val = '0;
    logic        flag_we = 1'b0;
    logic [31:0] result;
    logic [4:0]  status;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] q_res [$];
    logic [4:0]  q_st  [$];
    string       q_tag [$];
    logic [4:0]  exp_st = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flagged_alu uut (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .dst_val (dst_val),
        .src_val (src_val),
        .flag_we (flag_we),
        .result  (result),
        .status  (status)
    );

    function automatic logic [32:0] model(input logic [3:0] o,
                                          input logic [31:0] d,
                                          input logic [31:0] s);
        logic [32:0] r;
        logic [4:0]  n;
        logic [63:0] dd;
        n  = s[4:0];
        dd = {d, d};
        case (o)
            4'h4: r = {1'b0, d} + {1'b0, s};
            4'h5: r = {1'b0, d * s};
            4'h6: r = {1'b0, ~s};
            4'h7: r = {1'b0, d >> n};
            4'h8: r = {1'b0, dd[31:0] >> n} | {1'b0, d << (6'd32 - {1'b0, n})};
            default: r = '0;
        endcase
        if (o == 4'h8 && n == 0) r = {1'b0, d};
        return r;
    endfunction

    task automatic drive(input logic r, input logic [3:0] o,
                         input logic [31:0] d, input logic [31:0] s,
                         input logic we, input string tag);
        logic [32:0] m;
        logic [31:0] res;
        @(negedge clk);
        rst = r; op = o; dst_val = d; src_val = s; flag_we = we;
        m   = model(o, d, s);
        res = m[31:0];
        if (r) begin
            exp_st = '0;
        end else if (we && o >= 4'h4 && o <= 4'h8) begin
            exp_st = {res[31], res == 32'd0, ^res, ~res[0], (o == 4'h4) ? m[32] : 1'b0};
        end
        q_res.push_back(res);
        q_st.push_back(exp_st);
        q_tag.push_back(tag);
    endtask

    // Monitor: after each edge, compare result and status with the queue head.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (q_res.size() > 0) begin
                logic [31:0] er;
                logic [4:0]  es;
                string       t;
                er = q_res.pop_front();
                es = q_st.pop_front();
                t  = q_tag.pop_front();
                n_run++;
                if (result !== er) begin
                    n_fail++;
                    $display("FAIL %s result: got %h expected %h", t, result, er);
                end
                n_run++;
                if (status !== es) begin
                    n_fail++;
                    $display("FAIL %s status: got %b expected %b", t, status, es);
                end
            end
        end
    end

    initial begin
        // R10: reset state and reset priority over a valid write
        drive(1, 4'h4, 32'hFFFF_FFFF, 32'h1, 1, "R10 reset with write");
        drive(1, 4'h6, 32'h0, 32'h0, 1, "R10 reset hold");
        // R1: wrap with carry and zero
        drive(0, 4'h4, 32'hFFFF_FFFF, 32'h1, 1, "R1 wrap carry");
        drive(0, 4'h4, 32'h5, 32'h3, 1, "R1 small add");
        drive(0, 4'h4, 32'h7FFF_FFFF, 32'h1, 1, "R7 neg from add");
        // R2
        drive(0, 4'h5, 32'h1_0000, 32'h1_0000, 1, "R2 product high dropped");
        drive(0, 4'h5, 32'd7, 32'd6, 1, "R2 7x6");
        drive(0, 4'h5, 32'h1234_5678, 32'h9ABC_DEF1, 1, "R2 large");
        // R3
        drive(0, 4'h6, 32'hDEAD_BEEF, 32'h0, 1, "R3 invert zero");
        drive(0, 4'h6, 32'h0, 32'hFFFF_FFF8, 1, "R3 invert parity");
        // R4
        drive(0, 4'h7, 32'h8000_0000, 32'd31, 1, "R4 shift 31");
        drive(0, 4'h7, 32'hF0F0_F0F0, 32'd4, 1, "R4 shift 4");
        drive(0, 4'h7, 32'h0000_0001, 32'd1, 1, "R4 shift out");
        // R5
        drive(0, 4'h8, 32'h0000_0001, 32'd1, 1, "R5 rotate 1");
        drive(0, 4'h8, 32'h8000_0001, 32'd31, 1, "R5 rotate 31");
        drive(0, 4'h8, 32'h1234_5678, 32'hFFF0_0008, 1, "R5 rotate 8 high bits ignored");
        // R6
        drive(0, 4'h7, 32'hCAFE_0001, 32'd32, 1, "R6 shift count 32");
        drive(0, 4'h8, 32'hCAFE_0001, 32'd0, 1, "R6 rotate count 0");
        // R8: write enable low holds flags
        drive(0, 4'h4, 32'h0, 32'h0, 0, "R8 hold we low");
        drive(0, 4'h6, 32'h0, 32'h0, 0, "R8 hold we low invert");
        // R9: invalid codes
        drive(0, 4'h0, 32'h1, 32'h1, 1, "R9 code 0");
        drive(0, 4'hE, 32'hFFFF_FFFF, 32'h1, 1, "R9 code E");
        drive(0, 4'h9, 32'h3, 32'h3, 1, "R9 code 9");
        drive(0, 4'h3, 32'h3, 32'h3, 1, "R9 code 3");
        // R7: parity and even patterns
        drive(0, 4'h4, 32'h3, 32'h4, 1, "R7 odd parity");
        drive(0, 4'h4, 32'h2, 32'h4, 1, "R7 even parity even value");
        // R10 mid-run
        drive(1, 4'h5, 32'h3, 32'h3, 1, "R10 mid-run reset");
        drive(0, 4'h5, 32'h3, 32'h3, 1, "R2 after reset");
        @(negedge clk);
        flag_we = 0;
        repeat (3) @(posedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule